// File: doc/BRIEF.md
# Memory Test Command Generator

This block produces an endless stream of read and write commands intended to load an external memory controller during bring-up and soak testing. Each command is offered on a valid/ready handshake and carries a direction bit, a byte address and a burst length. Two four-bit mode inputs, which may change at runtime, choose how the direction and the burst length are picked. Each can be a fixed value taken from an input or a value drawn from an internal pseudo-random sequence. The direction can also be pinned to a write-only or read-only pattern aimed at address zero.

The random source is a 32-bit maximal-length linear feedback shift register. It moves one step for every accepted command. In random burst mode, one draw gives a length L, and the next L commands all carry that length. A pause input stops new commands at the next command boundary without a reset. Outside the address-zero modes, the address advances after each accepted command by its burst length times the beat width.

Top module: `mtg_cmd_gen`

## Requirements
- R1: During reset and in the first cycle after it, `cmd_valid` is low and `cmd_addr` is 0. If `pause` is low, the first command is presented one clock after the first rising edge with reset low.
- R2: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay unchanged. A command is accepted on an edge with both high. When `pause` is low, the next command is presented in the very next cycle, so commands flow back to back.
- R3: With `instr_mode` = 4'h1, `cmd_is_read` equals `fixed_instr` sampled when the command is formed (0 = write, 1 = read).
- R4: With `instr_mode` = 4'h2, `cmd_is_read` is bit 31 of state S_k. Here S_0 = 32'h1 and S_{k+1} = {S_k[30:0], S_k[31]^S_k[21]^S_k[1]^S_k[0]}, and k is the number of commands accepted since reset.
- R5: `instr_mode` = 4'hE gives writes to address 0 only, and 4'hF gives reads to address 0 only. Commands in these modes leave the running address unchanged.
- R6: Any `instr_mode` value other than 1, 2, E and F behaves as 4'h1.
- R7: With `burst_mode` = 4'h1, `cmd_len` equals `fixed_len`, sampled when the command is formed. A value of 0 is raised to 1 and a value above 256 is cut to 256.
- R8: With `burst_mode` = 4'h2, a new run starts whenever the previous run is used up or the previous command was not formed in this mode. The run length is L = S_k[7:0] + 1, and that run's L commands all carry `cmd_len` = L.
- R9: Any `burst_mode` value other than 1 and 2 behaves as 4'h1.
- R10: Outside modes E and F, `cmd_addr` equals the sum, modulo 2^32, of `cmd_len` × 8 over all earlier accepted commands that were not in mode E or F.
- R11: While `pause` is high at a command boundary, no new command is formed. A command already presented stays valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_mode | input | 4 | Direction selection mode |
| burst_mode | input | 4 | Burst length selection mode |
| fixed_instr | input | 1 | Direction used by fixed mode, 1 = read |
| fixed_len | input | 9 | Burst length used by fixed mode, legal 1..256 |
| pause | input | 1 | Holds off new commands at a boundary |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken by the controller |
| cmd_is_read | output | 1 | 1 = read, 0 = write |
| cmd_addr | output | 32 | Byte address of the command |
| cmd_len | output | 9 | Burst length in beats, 1..256 |

## Verification
All command fields are registered, so the inputs present before an edge that forms a command show up one cycle later. That edge is an accepting edge with `pause` low, or an idle edge with `pause` low. A direction, address or length is therefore due one clock after the mode and fixed inputs are sampled. After an acceptance, both the address and the random state are already updated in the next command. The bench drives inputs at the falling edge and advances its arithmetic model across the following rising edge. It compares every output at the next falling edge, so each expectation is checked exactly in the cycle it is due. A near-exhaustive sweep covers all 256 mode pairs under irregular ready and pause patterns.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    localparam int unsigned PRBS_W   = 32;
    localparam int unsigned LEN_W    = 9;
    localparam int unsigned DRAW_W   = LEN_W - 1;
    localparam logic [LEN_W-1:0]  LEN_MAX  = 9'd256;
    localparam logic [PRBS_W-1:0] TAP_MASK = 32'h8020_0003;

    typedef enum logic [1:0] {
        OP_FIXED,
        OP_RANDOM,
        OP_WRITE_AT_ZERO,
        OP_READ_AT_ZERO
    } op_sel_e;

    typedef enum logic {
        LEN_FIXED,
        LEN_RANDOM
    } len_sel_e;

    typedef struct packed {
        logic             is_read;
        logic             locked;
        logic [LEN_W-1:0] len;
    } cmd_attr_t;

    function automatic op_sel_e decode_op(input logic [3:0] code);
        case (code)
            4'h2:    return OP_RANDOM;
            4'hE:    return OP_WRITE_AT_ZERO;
            4'hF:    return OP_READ_AT_ZERO;
            default: return OP_FIXED;
        endcase
    endfunction

    function automatic len_sel_e decode_len(input logic [3:0] code);
        return (code == 4'h2) ? LEN_RANDOM : LEN_FIXED;
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], ^(s & TAP_MASK)};
    endfunction

    function automatic logic pick_read_bit(input logic [PRBS_W-1:0] s);
        return s[PRBS_W-1];
    endfunction

    function automatic logic [DRAW_W-1:0] pick_draw(input logic [PRBS_W-1:0] s);
        return s[DRAW_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        if (v == '0)
            return LEN_W'(1);
        else if (v > LEN_MAX)
            return LEN_MAX;
        else
            return v;
    endfunction

endpackage

// File: rtl/mtg_prbs.sv
module mtg_prbs
    import mtg_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [PRBS_W-1:0] state_o,
    output logic [PRBS_W-1:0] ahead_o
);

    logic [PRBS_W-1:0] state_q;

    assign ahead_o = prbs_step(state_q);
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (advance)
            state_q <= ahead_o;
    end

    // R4: the register never falls into the all-zero lock-up state
    p_prbs_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R4: the sequence moves only on an accepted command
    p_prbs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state_q));

endmodule

// File: rtl/mtg_len_pick.sv
module mtg_len_pick
    import mtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              form,
    input  len_sel_e          sel,
    input  logic [LEN_W-1:0]  fixed_len,
    input  logic [DRAW_W-1:0] draw_bits,
    output logic [LEN_W-1:0]  len_o
);

    logic [LEN_W-1:0] remain_q, remain_d;
    logic [LEN_W-1:0] run_q, run_d;

    always_comb begin
        if (sel == LEN_RANDOM) begin
            if (remain_q == '0) begin
                len_o    = LEN_W'({1'b0, draw_bits}) + LEN_W'(1);
                remain_d = len_o - LEN_W'(1);
            end else begin
                len_o    = run_q;
                remain_d = remain_q - LEN_W'(1);
            end
        end else begin
            len_o    = clamp_len(fixed_len);
            remain_d = '0;
        end
        run_d = len_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            run_q    <= LEN_W'(1);
        end else if (form) begin
            remain_q <= remain_d;
            run_q    <= run_d;
        end
    end

    // R7: every formed length is inside the legal range
    p_len_legal_r7: assert property (@(posedge clk) disable iff (rst)
        form |-> (len_o != '0) && (len_o <= LEN_MAX));

    // R8: a fresh random run leaves exactly length-1 commands to go
    p_run_start_r8: assert property (@(posedge clk) disable iff (rst)
        form && sel == LEN_RANDOM && remain_q == '0 |=> remain_q == run_q - LEN_W'(1));

    // R8: remaining count never exceeds the run it belongs to
    p_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
        remain_q < run_q);

endmodule

// File: rtl/mtg_addr_walk.sv
module mtg_addr_walk
    import mtg_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned BYTES_PER_BEAT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              locked,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] next_o
);

    localparam logic [ADDR_W-1:0] BEAT_BYTES = ADDR_W'(BYTES_PER_BEAT);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride;

    assign stride = ADDR_W'(len) * BEAT_BYTES;
    assign next_o = (accept && !locked) ? base_q + stride : base_q;
    assign base_o = base_q;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else
            base_q <= next_o;
    end

    // R5: commands pinned to address zero leave the running address alone
    p_lock_keeps_base_r5: assert property (@(posedge clk) disable iff (rst)
        accept && locked |=> $stable(base_q));

    // R10: the running address only moves on an acceptance
    p_base_moves_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(base_q));

endmodule

// File: rtl/mtg_cmd_gen.sv
module mtg_cmd_gen
    import mtg_pkg::*;
#(
    parameter int unsigned       ADDR_W         = 32,
    parameter int unsigned       BYTES_PER_BEAT = 8,
    parameter logic [PRBS_W-1:0] SEED           = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        instr_mode,
    input  logic [3:0]        burst_mode,
    input  logic              fixed_instr,
    input  logic [LEN_W-1:0]  fixed_len,
    input  logic              pause,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_is_read,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len
);

    logic              valid_q;
    cmd_attr_t         attr_q, attr_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    logic              accept;
    logic              form;
    op_sel_e           op_sel;
    len_sel_e          len_sel;
    logic [PRBS_W-1:0] prbs_state, prbs_ahead, prbs_src;
    logic [LEN_W-1:0]  picked_len;
    logic [ADDR_W-1:0] base_now, base_next;

    assign accept   = valid_q && cmd_ready;
    assign form     = !pause && (!valid_q || accept);
    assign op_sel   = decode_op(instr_mode);
    assign len_sel  = decode_len(burst_mode);
    assign prbs_src = accept ? prbs_ahead : prbs_state;

    mtg_prbs #(
        .SEED (SEED)
    ) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .advance (accept),
        .state_o (prbs_state),
        .ahead_o (prbs_ahead)
    );

    mtg_len_pick u_len (
        .clk       (clk),
        .rst       (rst),
        .form      (form),
        .sel       (len_sel),
        .fixed_len (fixed_len),
        .draw_bits (pick_draw(prbs_src)),
        .len_o     (picked_len)
    );

    mtg_addr_walk #(
        .ADDR_W         (ADDR_W),
        .BYTES_PER_BEAT (BYTES_PER_BEAT)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .locked (attr_q.locked),
        .len    (attr_q.len),
        .base_o (base_now),
        .next_o (base_next)
    );

    always_comb begin
        attr_d.len = picked_len;
        case (op_sel)
            OP_RANDOM: begin
                attr_d.is_read = pick_read_bit(prbs_src);
                attr_d.locked  = 1'b0;
            end
            OP_WRITE_AT_ZERO: begin
                attr_d.is_read = 1'b0;
                attr_d.locked  = 1'b1;
            end
            OP_READ_AT_ZERO: begin
                attr_d.is_read = 1'b1;
                attr_d.locked  = 1'b1;
            end
            default: begin
                attr_d.is_read = fixed_instr;
                attr_d.locked  = 1'b0;
            end
        endcase
        addr_d = attr_d.locked ? '0 : base_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            attr_q  <= '{is_read: 1'b0, locked: 1'b0, len: LEN_W'(1)};
            addr_q  <= '0;
        end else if (form) begin
            valid_q <= 1'b1;
            attr_q  <= attr_d;
            addr_q  <= addr_d;
        end else if (accept) begin
            valid_q <= 1'b0;
        end
    end

    assign cmd_valid   = valid_q;
    assign cmd_is_read = attr_q.is_read;
    assign cmd_addr    = addr_q;
    assign cmd_len     = attr_q.len;

    // R2: an offered command is held unchanged until it is taken
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_is_read)
                                    && $stable(cmd_addr) && $stable(cmd_len));

    // R11: an idle generator stays idle while paused
    p_pause_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid && pause |=> !cmd_valid);

    // R5: commands pinned to zero carry address zero
    p_lock_addr_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && attr_q.locked |-> cmd_addr == '0);

    // R1: the first command appears one clock after reset is released
    p_start_r1: assert property (@(posedge clk)
        $fell(rst) && !pause |=> cmd_valid);

endmodule

// File: tb/mtg_cmd_gen_tb.sv
module mtg_cmd_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] instr_mode = 4'h1;
    logic [3:0] burst_mode = 4'h1;
    logic       fixed_instr = 1'b0;
    logic [8:0] fixed_len = 9'd4;
    logic       pause = 1'b0;
    logic       cmd_ready = 1'b0;
    logic       cmd_valid;
    logic       cmd_is_read;
    logic [31:0] cmd_addr;
    logic [8:0] cmd_len;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mtg_cmd_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .instr_mode  (instr_mode),
        .burst_mode  (burst_mode),
        .fixed_instr (fixed_instr),
        .fixed_len   (fixed_len),
        .pause       (pause),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_is_read (cmd_is_read),
        .cmd_addr    (cmd_addr),
        .cmd_len     (cmd_len)
    );

    // model state
    logic        m_valid = 1'b0;
    logic        m_read = 1'b0;
    logic        m_locked = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_base = '0;
    logic [31:0] m_prbs = 32'h1;
    int          m_len = 1;
    int          m_run = 1;
    int          m_remain = 0;
    string       t_read = "R3";
    string       t_addr = "R10";
    string       t_len  = "R7";

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], fb};
    endfunction

    function automatic int legal_len(input int v);
        if (v < 1) return 1;
        if (v > 256) return 256;
        return v;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input logic pz);
        chk(pz ? "R11" : "R2", "cmd_valid", 32'(cmd_valid), 32'(m_valid));
        if (m_valid) begin
            chk(t_read, "cmd_is_read", 32'(cmd_is_read), 32'(m_read));
            chk(t_addr, "cmd_addr", cmd_addr, m_addr);
            chk(t_len, "cmd_len", 32'(cmd_len), 32'(m_len));
        end
    endtask

    // one clock: drive inputs, advance the model across the rising edge
    task automatic cycle(input logic [3:0] im, input logic [3:0] bm, input logic fi,
                         input int fl, input logic pz, input logic rdy);
        logic acc;
        logic frm;
        instr_mode  = im;
        burst_mode  = bm;
        fixed_instr = fi;
        fixed_len   = 9'(fl);
        pause       = pz;
        cmd_ready   = rdy;
        acc = m_valid && rdy;
        if (acc) begin
            if (!m_locked) m_base = m_base + 32'(m_len) * 32'd8;
            m_prbs = lfsr_next(m_prbs);
        end
        frm = !pz && (!m_valid || acc);
        if (frm) begin
            case (im)
                4'h1: begin m_read = fi; m_locked = 1'b0; t_read = "R3"; end
                4'h2: begin m_read = m_prbs[31]; m_locked = 1'b0; t_read = "R4"; end
                4'hE: begin m_read = 1'b0; m_locked = 1'b1; t_read = "R5"; end
                4'hF: begin m_read = 1'b1; m_locked = 1'b1; t_read = "R5"; end
                default: begin m_read = fi; m_locked = 1'b0; t_read = "R6"; end
            endcase
            if (bm == 4'h2) begin
                if (m_remain == 0) begin
                    m_run    = int'(m_prbs[7:0]) + 1;
                    m_remain = m_run - 1;
                end else begin
                    m_remain = m_remain - 1;
                end
                m_len = m_run;
                t_len = "R8";
            end else begin
                m_len    = legal_len(fl);
                m_remain = 0;
                t_len    = (bm == 4'h1) ? "R7" : "R9";
            end
            m_addr = m_locked ? 32'h0 : m_base;
            t_addr = m_locked ? "R5" : "R10";
            m_valid = 1'b1;
        end else if (acc) begin
            m_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs(pz);
    endtask

    initial begin
        int fl_set [8] = '{0, 1, 2, 7, 255, 256, 257, 511};
        int cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle while in reset
        chk("R1", "cmd_valid in reset", 32'(cmd_valid), 32'd0);
        chk("R1", "cmd_addr in reset", cmd_addr, 32'd0);
        rst = 1'b0;
        // R1: still idle before the first edge with reset low
        #0.5;
        chk("R1", "cmd_valid after release", 32'(cmd_valid), 32'd0);
        // R1: first command one clock later, fixed write of length 4 at 0
        cycle(4'h1, 4'h1, 1'b0, 4, 1'b0, 1'b0);
        chk("R1", "first cmd_valid", 32'(cmd_valid), 32'd1);
        chk("R1", "first cmd_addr", cmd_addr, 32'd0);

        // near-exhaustive sweep over all mode pairs
        for (int im = 0; im < 16; im++) begin
            for (int bm = 0; bm < 16; bm++) begin
                for (int k = 0; k < 30; k++) begin
                    cycle(4'(im), 4'(bm), 1'(cyc >> 3), fl_set[cyc % 8],
                          ((cyc % 53) >= 47), (((cyc * 7) % 11) < 8));
                    cyc++;
                end
            end
        end

        // long random runs with a free-flowing consumer
        for (int k = 0; k < 3000; k++) begin
            cycle(4'h2, 4'h2, 1'b0, 1, 1'b0, 1'b1);
        end

        // R11: pause while a command is held, then release
        for (int k = 0; k < 40; k++) begin
            cycle(4'h1, 4'h1, 1'b1, 16, (k >= 10 && k < 25), (k % 3 != 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule